// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from a set of peripheral sources into a pending-status register and gates them with an enable-mask register. Both registers sit on a simple register bus with address, write strobe, write data, byte-lane enables and combinational read data. A source input that is high in a clock cycle latches its status bit. Software acknowledges a source by writing the status register. The written word is ANDed into the current contents, so a 0 clears a bit and a 1 leaves it as it was. The mask register takes the written value as it is.

The request line to the processor comes from a two-state machine. In `IRQ_QUIET` the line is low, and the machine moves to `IRQ_RAISED` (transition *raise*) on the edge after some pending bit is also enabled. In `IRQ_RAISED` the line is high, and the machine returns to `IRQ_QUIET` (transition *drop*) on the edge after no enabled bit is pending. Otherwise the machine holds its state. A mask write that enables a source which is already pending also produces a one-cycle recheck pulse, so the processor can re-evaluate its interrupt state at once. Status bit 3 carries the DMA interrupt source. A 16-bit access uses byte enables `0011` and touches only the low half of a register.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset the status and mask registers read zero, and `cpu_irq` and `irq_recheck` are low.
- R2: A write to offset 0x70 replaces each enabled byte lane of status with (status AND write data). A status bit never goes from 0 to 1 without its source input.
- R3: A write to offset 0x74 stores the write data into each enabled byte lane of the mask. Without a mask write the mask does not change.
- R4: `src_req[i]` high in a cycle sets status bit i at the next edge, even when a write in that same cycle clears the bit. Bit 3 is the DMA source.
- R5: Byte lanes whose `reg_be` bit is 0 (lane k covers data bits 8k+7..8k) keep their value. A 16-bit write (`reg_be`=0011) leaves bits 31..16 of either register unchanged.
- R6: `cpu_irq` is high in the cycle after (status AND mask) is nonzero, and low in the cycle after it is zero.
- R7: `irq_recheck` is high for exactly the cycle after a mask write whose new mask value overlaps the status bits pending in the write cycle. It is low in every other cycle.
- R8: `reg_rdata` shows status at offset 0x70 and mask at offset 0x74, with bits at and above `NUM_SRC` reading zero. Any other offset reads zero, and a write to another offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| src_req | input | NUM_SRC | Source request inputs, one per status bit |
| cpu_irq | output | 1 | Registered level interrupt request |
| irq_recheck | output | 1 | One-cycle pulse after an unmask of a pending source |

## Verification
The embedded assertions check on every cycle that source requests always land in status, that no status bit rises by itself, that the mask holds its value between writes and keeps disabled lanes on a write, and that the request state machine follows the pending-and-enabled condition one edge later. The recheck pulse is checked only for its cause, a preceding mask write. The bench scenarios must show the AND-on-write acknowledgement, a source winning over a clearing write in the same cycle, 16-bit partial writes, reads at unmapped offsets, and whether a recheck pulse appears or stays absent. A behavioural model compared on every clock covers these under random traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BUS_W = 32;
    localparam int BE_W  = BUS_W / 8;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irqc_status_reg.sv
module irqc_status_reg
    import irqc_pkg::*;
#(
    parameter logic [BUS_W-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] lane_bits,
    input  logic [BUS_W-1:0] src_ext,
    output logic [BUS_W-1:0] status_q
);
    logic [BUS_W-1:0] acked;
    logic [BUS_W-1:0] status_d;

    always_comb begin
        acked = status_q;
        if (wr) begin
            // Only enabled lanes see the AND; a zero bit there clears.
            acked = status_q & ~(lane_bits & ~wdata);
        end
        // New requests are merged last so they win over a clear.
        status_d = (acked | src_ext) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    p_src_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext != '0) |=> ((status_q & $past(src_ext)) == $past(src_ext)));

    p_no_stray_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(src_ext)) == '0));
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
    import irqc_pkg::*;
#(
    parameter logic [BUS_W-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] lane_bits,
    output logic [BUS_W-1:0] mask_q,
    output logic [BUS_W-1:0] mask_d
);
    always_comb begin
        mask_d = mask_q;
        if (wr) begin
            mask_d = ((mask_q & ~lane_bits) | (wdata & lane_bits)) & IMPL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_q));

    p_mask_lanes_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((mask_q & ~$past(lane_bits)) == ($past(mask_q) & ~$past(lane_bits))));
endmodule

// File: rtl/irqc_req_fsm.sv
module irqc_req_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_any,
    output logic cpu_irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending_any)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending_any) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        cpu_irq = (state_q == IRQ_RAISED);
    end

    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pending_any |=> cpu_irq);

    p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_any |=> !cpu_irq);
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int                NUM_SRC    = 20,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 8'h74
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [BUS_W-1:0]   reg_wdata,
    input  logic [BE_W-1:0]    reg_be,
    output logic [BUS_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               cpu_irq,
    output logic               irq_recheck
);
    localparam logic [BUS_W-1:0] IMPL_MASK =
        (NUM_SRC >= BUS_W) ? {BUS_W{1'b1}} : ((BUS_W'(1) << NUM_SRC) - BUS_W'(1));

    logic [BUS_W-1:0] lane_bits;
    logic [BUS_W-1:0] src_ext;
    logic [BUS_W-1:0] status_q;
    logic [BUS_W-1:0] mask_q;
    logic [BUS_W-1:0] mask_d;
    logic             wr_status;
    logic             wr_mask;
    logic             pending_any;
    logic             recheck_q;

    for (genvar b = 0; b < BUS_W; b++) begin : g_lane
        assign lane_bits[b] = reg_be[b / 8];
    end

    always_comb begin
        src_ext = '0;
        src_ext[NUM_SRC-1:0] = src_req;
    end

    assign wr_status   = reg_wr && (reg_addr == STATUS_OFS);
    assign wr_mask     = reg_wr && (reg_addr == MASK_OFS);
    assign pending_any = |(status_q & mask_q);

    irqc_status_reg #(.IMPL_MASK(IMPL_MASK)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_status),
        .wdata     (reg_wdata),
        .lane_bits (lane_bits),
        .src_ext   (src_ext),
        .status_q  (status_q)
    );

    irqc_mask_reg #(.IMPL_MASK(IMPL_MASK)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_mask),
        .wdata     (reg_wdata),
        .lane_bits (lane_bits),
        .mask_q    (mask_q),
        .mask_d    (mask_d)
    );

    irqc_req_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_any (pending_any),
        .cpu_irq     (cpu_irq)
    );

    // Recheck compares the incoming mask with what is pending right now.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recheck_q <= 1'b0;
        end else begin
            recheck_q <= wr_mask && ((status_q & mask_d) != '0);
        end
    end

    assign irq_recheck = recheck_q;

    always_comb begin
        if (reg_addr == STATUS_OFS) begin
            reg_rdata = status_q;
        end else if (reg_addr == MASK_OFS) begin
            reg_rdata = mask_q;
        end else begin
            reg_rdata = '0;
        end
    end

    p_recheck_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_recheck |-> $past(wr_mask));

    p_unused_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | mask_q) & ~IMPL_MASK) == '0);
endmodule

// File: tb/test_irqc_ctrl.sv
`timescale 1ns/1ps
module test_irqc_ctrl;
    localparam int NSRC = 20;
    localparam logic [31:0] VALID = 32'h000F_FFFF;
    localparam logic [7:0] A_ST = 8'h70;
    localparam logic [7:0] A_MK = 8'h74;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [3:0]      reg_be = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic            cpu_irq;
    logic            irq_recheck;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_status, m_mask;
    logic        m_irq, m_rchk;

    always #4 clk = ~clk;

    irqc_ctrl i_irqc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .src_req(src_req), .cpu_irq(cpu_irq), .irq_recheck(irq_recheck)
    );

    function automatic logic [31:0] expand(input logic [3:0] be);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = {8{be[k]}};
        return r;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        logic [31:0] ln, ns, nm;
        if (!rst_n) begin
            m_status = '0; m_mask = '0; m_irq = 1'b0; m_rchk = 1'b0;
        end else begin
            ln = expand(reg_be);
            ns = m_status;
            nm = m_mask;
            if (reg_wr && reg_addr == A_ST) ns = m_status & (reg_wdata | ~ln);
            if (reg_wr && reg_addr == A_MK) nm = ((m_mask & ~ln) | (reg_wdata & ln)) & VALID;
            ns = (ns | 32'(src_req)) & VALID;
            m_rchk = reg_wr && (reg_addr == A_MK) && ((m_status & nm) != 0);
            m_irq = (m_status & m_mask) != 0;
            m_status = ns;
            m_mask = nm;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Per-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            logic [31:0] er;
            er = (reg_addr == A_ST) ? m_status : (reg_addr == A_MK) ? m_mask : 32'h0;
            chk("R8 model read", reg_rdata, er);
            chk("R6 model irq", 32'(cpu_irq), 32'(m_irq));
            chk("R7 model recheck", 32'(irq_recheck), 32'(m_rchk));
        end
    end

    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                        input logic [3:0] be, input logic [NSRC-1:0] s);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; reg_be = be; src_req = s;
    endtask

    task automatic rd(input logic [7:0] a);
        step(a, 1'b0, 32'h0, 4'h0, '0);
        #2;
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(A_ST); chk("R1 status after reset", reg_rdata, 32'h0);
        chk("R1 irq after reset", 32'(cpu_irq), 32'h0);
        chk("R1 recheck after reset", 32'(irq_recheck), 32'h0);
        rd(A_MK); chk("R1 mask after reset", reg_rdata, 32'h0);

        // Sources 0, 3 (DMA) and 17
        step(A_ST, 1'b0, 32'h0, 4'h0, 20'h20009);
        rd(A_ST); chk("R4 sources latched incl DMA bit 3", reg_rdata, 32'h0002_0009);
        rd(A_ST); chk("R6 masked sources give no irq", 32'(cpu_irq), 32'h0);

        // Unmask DMA bit
        step(A_MK, 1'b1, 32'h0000_0008, 4'hF, '0);
        rd(A_MK); chk("R3 mask stored", reg_rdata, 32'h8);
        chk("R7 recheck on unmask of pending", 32'(irq_recheck), 32'h1);
        rd(A_MK); chk("R7 recheck lasts one cycle", 32'(irq_recheck), 32'h0);
        chk("R6 irq raised", 32'(cpu_irq), 32'h1);

        // Acknowledge DMA bit by writing zero there
        step(A_ST, 1'b1, 32'hFFFF_FFF7, 4'hF, '0);
        rd(A_ST); chk("R2 AND-on-write clears bit 3 only", reg_rdata, 32'h0002_0001);
        rd(A_ST); chk("R6 irq dropped", 32'(cpu_irq), 32'h0);

        // 16-bit mask write keeps upper half
        step(A_MK, 1'b1, 32'hFFFF_FFFF, 4'hF, '0);
        step(A_MK, 1'b1, 32'h0000_0000, 4'h3, '0);
        rd(A_MK); chk("R5 16-bit mask write keeps high half", reg_rdata, 32'h000F_0000);
        chk("R7 recheck on overlap with bit 17", 32'(irq_recheck), 32'h1);

        // 16-bit status write keeps upper half
        step(A_ST, 1'b1, 32'h0000_0000, 4'h3, '0);
        rd(A_ST); chk("R5 16-bit status write keeps high half", reg_rdata, 32'h0002_0000);

        // Source wins against a full clear in the same cycle
        step(A_ST, 1'b1, 32'h0000_0000, 4'hF, 20'h00020);
        rd(A_ST); chk("R4 source beats clearing write", reg_rdata, 32'h0000_0020);

        // Unmapped offset
        step(8'h78, 1'b1, 32'hFFFF_FFFF, 4'hF, '0);
        rd(8'h78); chk("R8 unmapped offset reads zero", reg_rdata, 32'h0);
        rd(A_ST); chk("R8 unmapped write leaves status", reg_rdata, 32'h0000_0020);
        rd(A_MK); chk("R8 unmapped write leaves mask", reg_rdata, 32'h000F_0000);

        // Mask write with no overlap: no pulse
        step(A_MK, 1'b1, 32'h0000_0001, 4'hF, '0);
        rd(A_MK); chk("R7 no recheck without overlap", 32'(irq_recheck), 32'h0);
        chk("R3 mask replaced", reg_rdata, 32'h1);

        step(A_MK, 1'b1, 32'hFFFF_FFFF, 4'hF, '0);
        rd(A_MK); chk("R8 bits above NUM_SRC read zero", reg_rdata, 32'h000F_FFFF);

        // Random traffic checked by the model
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [3:0] be;
            case ($urandom_range(3))
                0: a = A_ST;
                1: a = A_MK;
                2: a = 8'h78;
                default: a = A_ST;
            endcase
            case ($urandom_range(2))
                0: be = 4'h3;
                1: be = 4'hC;
                default: be = 4'hF;
            endcase
            step(a, 1'($urandom_range(1)), $urandom, be,
                 NSRC'($urandom & $urandom & $urandom));
        end
        step(A_ST, 1'b0, 32'h0, 4'h0, '0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule